// File: doc/BRIEF.md
# One-of-Four Return-to-Zero Link Endpoint

This block is a clocked model of both ends of a delay-insensitive packet link. On the transmit side, packet bytes arrive on a valid/ready stream with a last-byte flag. Each byte is cut into 2-bit symbols. Each symbol is sent by raising exactly one of four data lines. All lines return low between symbols, and a single acknowledge line paces the four-phase handshake. After the last byte of a packet, a separate end-of-packet line carries a token of its own. Together with the acknowledge, the link uses six lines.

On the receive side, the incoming lines are decoded and the symbols are packed back into bytes, which leave on a valid/ready stream with the last flag restored. A completed byte is held back until the next token arrives, because only that token tells whether the byte ended its packet. Patterns that break the code raise a one-cycle error pulse. Every line that crosses between the two ends passes through a two-flop synchronizer, so the handshake itself sets the link timing.

Stream rules: an input byte is taken on a cycle where `s_valid` and `s_ready` are both high. `s_ready` is high only while the transmitter is idle. On the output, `m_valid` stays high with `m_data`/`m_last` stable until `m_ready` is seen. While the output cannot take a byte, the receiver holds back its acknowledge, which stalls the remote transmitter.

Top module: `l4rz_link_endpoint`

## Requirements
- R1: Each data symbol of value v (0..3) raises only data line v. The end-of-packet line is never high together with a data line, and at most one of the five transmit lines is high at any time.
- R2: The transmit lines move only between all-low and a single token pattern. A token is held until the synchronized acknowledge is high, then dropped. The next token starts only after the acknowledge is seen low again.
- R3: A byte goes out as four symbols, lowest two bits first. Byte 0xE4 produces data-line masks 0001, 0010, 0100, 1000 in that order.
- R4: After the four symbols of a byte taken with `s_last`=1, the transmitter sends an end-of-packet token on its own line, with all four data lines low, using its own full handshake.
- R5: `s_ready` is low from the cycle after a byte is accepted until every handshake for that byte, including any end-of-packet token, has completed. Transmit lines are all low whenever `s_ready` is high.
- R6: During and right after reset, all transmit lines and `rx_ack` are low, `m_valid` and `rx_err` are low, and `s_ready` is high.
- R7: The receiver rebuilds each byte from four symbols, the first symbol in bits 1:0. It presents the byte with `m_last`=1 when an end-of-packet token follows it, and with `m_last`=0 when a data symbol follows it.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_last` hold. A token that needs the occupied output is left unacknowledged until the output frees.
- R9: A pattern with two or more of the five receive lines high raises `rx_err` for one cycle. The token is acknowledged and discarded, and no byte is produced.
- R10: An end-of-packet token that arrives after one to three symbols of a byte raises `rx_err`. The partial byte is dropped, and the next symbol starts a new byte.
- R11: `rx_ack` rises only on a non-zero receive pattern. It stays high while that pattern is held, and falls only after all five receive lines are seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Transmitter can take a byte |
| s_data | input | BYTE_W | Input byte |
| s_last | input | 1 | Input byte ends its packet |
| tx_dat | output | 4 | One-hot transmit data lines |
| tx_eop | output | 1 | Transmit end-of-packet line |
| tx_ack | input | 1 | Acknowledge from the remote receiver |
| rx_dat | input | 4 | One-hot receive data lines |
| rx_eop | input | 1 | Receive end-of-packet line |
| rx_ack | output | 1 | Acknowledge to the remote transmitter |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream takes the byte |
| m_data | output | BYTE_W | Output byte |
| m_last | output | 1 | Output byte ends its packet |
| rx_err | output | 1 | One-cycle pulse on an illegal pattern or a truncated byte |

## Verification
Two events in the receiver can fall in the same cycle. One is the downstream draining the output register with `m_ready`. The other is a newly decoded token pushing the held byte into that register, either the first symbol of the next byte or an end-of-packet token. The table-driven loopback run provokes this by toggling `m_ready` in a pattern that is not aligned with the symbol rhythm. The result is judged by comparing every received byte and last flag with the table in order, so a lost or duplicated byte shows up there. A directed run holds `m_ready` low for a long time, checks that the output and the stalled end-of-packet line stay frozen with the acknowledge held back, and then releases it.

// File: rtl/l4rz_pkg.sv
`timescale 1ns/1ps
package l4rz_pkg;
  localparam int LANES = 4;  // one-hot data lines per symbol
  localparam int SYM_W = 2;  // bits carried per symbol

  typedef enum logic [2:0] {
    TX_IDLE, TX_SYM, TX_SYM_RZ, TX_EOP, TX_EOP_RZ
  } tx_state_t;

  typedef enum logic {
    RX_WAIT, RX_HOLD
  } rx_state_t;

  function automatic logic [SYM_W-1:0] lane_to_sym(input logic [LANES-1:0] v);
    logic [SYM_W-1:0] r;
    r = '0;
    for (int i = 0; i < LANES; i++)
      if (v[i]) r = SYM_W'(i);
    return r;
  endfunction

  function automatic int unsigned ones5(input logic [LANES:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i <= LANES; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/l4rz_sync.sv
`timescale 1ns/1ps
module l4rz_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/l4rz_tx.sv
`timescale 1ns/1ps
module l4rz_tx
  import l4rz_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  output logic [LANES-1:0]  tx_dat,
  output logic              tx_eop,
  input  logic              tx_ack
);
  localparam int SYMS  = BYTE_W / SYM_W;
  localparam int IDX_W = (SYMS > 1) ? $clog2(SYMS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SYMS - 1);

  tx_state_t         state;
  logic [BYTE_W-1:0] byte_q;
  logic              last_q;
  logic [IDX_W-1:0]  idx_q;
  logic              ack_s;

  l4rz_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(tx_ack), .q(ack_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= TX_IDLE;
      byte_q <= '0;
      last_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      case (state)
        TX_IDLE: if (s_valid) begin
          byte_q <= s_data;
          last_q <= s_last;
          idx_q  <= '0;
          state  <= TX_SYM;
        end
        TX_SYM:    if (ack_s) state <= TX_SYM_RZ;
        TX_SYM_RZ: if (!ack_s) begin
          if (idx_q == IDX_LAST) begin
            state <= last_q ? TX_EOP : TX_IDLE;
          end else begin
            idx_q  <= idx_q + 1'b1;
            byte_q <= byte_q >> SYM_W;
            state  <= TX_SYM;
          end
        end
        TX_EOP:    if (ack_s) state <= TX_EOP_RZ;
        TX_EOP_RZ: if (!ack_s) state <= TX_IDLE;
        default:   state <= TX_IDLE;
      endcase
    end
  end

  assign s_ready = (state == TX_IDLE);
  assign tx_dat  = (state == TX_SYM) ? (LANES'(1) << byte_q[SYM_W-1:0]) : '0;
  assign tx_eop  = (state == TX_EOP);

  // Assertions
  logic [LANES:0] tok;
  assign tok = {tx_eop, tx_dat};

  assert_tx_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tok));

  assert_tx_rz_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tok != '0) |=> (tok == '0) || (tok == $past(tok)));

  assert_tx_drop_after_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|tok) |-> $past(ack_s));

  assert_tx_ready_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (tok == '0));
endmodule

// File: rtl/l4rz_rx.sv
`timescale 1ns/1ps
module l4rz_rx
  import l4rz_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  rx_dat,
  input  logic              rx_eop,
  output logic              rx_ack,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BYTE_W-1:0] m_data,
  output logic              m_last,
  output logic              rx_err
);
  localparam int SYMS  = BYTE_W / SYM_W;
  localparam int IDX_W = (SYMS > 1) ? $clog2(SYMS) : 1;
  localparam int SH_W  = BYTE_W - SYM_W;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SYMS - 1);

  rx_state_t         state;
  logic [LANES:0]    code_s;
  logic [IDX_W-1:0]  idx_q;
  logic [SH_W-1:0]   sh_q;
  logic              pend_v;
  logic [BYTE_W-1:0] pend_d;
  logic              multi, out_free;
  logic [SYM_W-1:0]  sym;

  l4rz_sync #(.W(LANES + 1), .STAGES(SYNC_STAGES)) u_line_sync (
    .clk(clk), .rst_n(rst_n), .d({rx_eop, rx_dat}), .q(code_s)
  );

  always_comb begin
    multi    = ones5(code_s) > 1;
    out_free = !m_valid || m_ready;
    sym      = lane_to_sym(code_s[LANES-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= RX_WAIT;
      idx_q   <= '0;
      sh_q    <= '0;
      pend_v  <= 1'b0;
      pend_d  <= '0;
      m_valid <= 1'b0;
      m_data  <= '0;
      m_last  <= 1'b0;
      rx_err  <= 1'b0;
    end else begin
      rx_err <= 1'b0;
      if (m_valid && m_ready) m_valid <= 1'b0;
      case (state)
        RX_WAIT: if (code_s != '0) begin
          if (multi) begin
            rx_err <= 1'b1;
            state  <= RX_HOLD;
          end else if (code_s[LANES]) begin
            if (idx_q != '0) begin
              rx_err <= 1'b1;
              idx_q  <= '0;
              state  <= RX_HOLD;
            end else if (!pend_v) begin
              state <= RX_HOLD;
            end else if (out_free) begin
              m_valid <= 1'b1;
              m_data  <= pend_d;
              m_last  <= 1'b1;
              pend_v  <= 1'b0;
              state   <= RX_HOLD;
            end
          end else if (!(pend_v && !out_free)) begin
            if (pend_v) begin
              m_valid <= 1'b1;
              m_data  <= pend_d;
              m_last  <= 1'b0;
              pend_v  <= 1'b0;
            end
            if (idx_q == IDX_LAST) begin
              pend_d <= {sym, sh_q};
              pend_v <= 1'b1;
              idx_q  <= '0;
            end else begin
              sh_q  <= {sym, sh_q[SH_W-1:SYM_W]};
              idx_q <= idx_q + 1'b1;
            end
            state <= RX_HOLD;
          end
        end
        RX_HOLD: if (code_s == '0) state <= RX_WAIT;
        default: state <= RX_WAIT;
      endcase
    end
  end

  assign rx_ack = (state == RX_HOLD);

  // Assertions
  assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid && $stable(m_data) && $stable(m_last));

  assert_rx_ack_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ack) |-> ($past(code_s) == '0));

  assert_rx_ack_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ack) |-> ($past(code_s) != '0));

  assert_rx_err_acked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> rx_ack);
endmodule

// File: rtl/l4rz_link_endpoint.sv
`timescale 1ns/1ps
module l4rz_link_endpoint #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  output logic [3:0]        tx_dat,
  output logic              tx_eop,
  input  logic              tx_ack,
  input  logic [3:0]        rx_dat,
  input  logic              rx_eop,
  output logic              rx_ack,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BYTE_W-1:0] m_data,
  output logic              m_last,
  output logic              rx_err
);
  l4rz_tx #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .tx_dat(tx_dat), .tx_eop(tx_eop), .tx_ack(tx_ack)
  );

  l4rz_rx #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .rx_dat(rx_dat), .rx_eop(rx_eop), .rx_ack(rx_ack),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .rx_err(rx_err)
  );

  // Assertion
  assert_reset_quiet_R6: assert property (@(posedge clk)
    $past(!rst_n) |-> (tx_dat == '0) && !tx_eop && !rx_ack && !m_valid && !rx_err);
endmodule

// File: tb/tb_l4rz_link_endpoint.sv
`timescale 1ns/1ps
module tb_l4rz_link_endpoint;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       s_valid = 1'b0, s_ready, s_last = 1'b0;
  logic [7:0] s_data = '0;
  logic [3:0] tx_dat, rx_dat, b_dat = '0;
  logic       tx_eop, tx_ack, rx_eop, rx_ack, b_eop = 1'b0, b_ack = 1'b0;
  logic       m_valid, m_ready, m_last, rx_err;
  logic [7:0] m_data;
  logic       lb = 1'b0;

  assign tx_ack = lb ? rx_ack : b_ack;
  assign rx_dat = lb ? tx_dat : b_dat;
  assign rx_eop = lb ? tx_eop : b_eop;

  l4rz_link_endpoint dut (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .tx_dat(tx_dat), .tx_eop(tx_eop), .tx_ack(tx_ack),
    .rx_dat(rx_dat), .rx_eop(rx_eop), .rx_ack(rx_ack),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .rx_err(rx_err)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // {last, data}
  localparam logic [8:0] VEC [9] = '{
    9'h0A5, 9'h13C, 9'h100, 9'h0FF, 9'h0E4, 9'h11B, 9'h181, 9'h055, 9'h1AA
  };

  // downstream ready driver
  bit rdy_toggle = 1'b0, rdy_force = 1'b1;
  int cyc = 0;
  initial m_ready = 1'b1;
  always @(posedge clk) begin
    #1;
    m_ready = rdy_toggle ? ((cyc % 5) != 1 && (cyc % 7) != 3) : rdy_force;
    cyc++;
  end

  // monitors
  logic [8:0] rxbuf [64];
  int rx_n = 0, err_n = 0, rz_bad = 0, oh_bad = 0;
  logic [4:0] prev_tok = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_valid && m_ready && rx_n < 64) begin
        rxbuf[rx_n] = {m_last, m_data};
        rx_n++;
      end
      if (rx_err) err_n++;
      if ($countones({tx_eop, tx_dat}) > 1) oh_bad++;
      if (prev_tok != 0 && {tx_eop, tx_dat} != 0 && {tx_eop, tx_dat} != prev_tok) rz_bad++;
      prev_tok = {tx_eop, tx_dat};
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic l);
    @(posedge clk); #1;
    s_valid = 1'b1; s_data = d; s_last = l;
    for (int t = 0; t < 5000; t++) begin
      @(negedge clk);
      if (s_ready) break;
    end
    @(posedge clk); #1;
    s_valid = 1'b0;
  endtask

  task automatic wait_ack(input logic v, input string tag);
    bit seen;
    seen = 1'b0;
    for (int t = 0; t < 100; t++) begin
      @(negedge clk);
      if (rx_ack == v) begin seen = 1'b1; break; end
    end
    if (!seen) chk(1'b0, tag, int'(rx_ack), int'(v));
  endtask

  task automatic put_tok(input logic [4:0] p);
    @(posedge clk); #1;
    {b_eop, b_dat} = p;
    wait_ack(1'b1, "R11 ack rise");
    @(posedge clk); #1;
    {b_eop, b_dat} = '0;
    wait_ack(1'b0, "R11 ack fall");
  endtask

  task automatic put_byte(input logic [7:0] d);
    for (int k = 0; k < 4; k++) put_tok(5'(4'b0001 << d[2*k +: 2]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int e0, n0;
    // reset state
    cycles(3);
    chk(tx_dat == 0 && !tx_eop && !rx_ack && !m_valid && !rx_err, "R6 lines in reset",
        {tx_eop, tx_dat, rx_ack, m_valid}, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    cycles(2);
    chk(s_ready == 1'b1, "R6 s_ready after reset", s_ready, 1);
    chk(tx_dat == 0 && !tx_eop && !rx_ack && !m_valid, "R6 quiet after reset",
        {tx_eop, tx_dat, rx_ack, m_valid}, 0);

    // table walk over loopback with irregular m_ready
    lb = 1'b1; rdy_toggle = 1'b1;
    foreach (VEC[i]) send_byte(VEC[i][7:0], VEC[i][8]);
    for (int t = 0; t < 20000 && rx_n < 9; t++) cycles(1);
    chk(rx_n == 9, "R7 byte count", rx_n, 9);
    foreach (VEC[i]) chk(rxbuf[i] == VEC[i], "R7 table byte", rxbuf[i], VEC[i]);
    chk(oh_bad == 0, "R1 one-hot lines", oh_bad, 0);
    chk(rz_bad == 0, "R2 return-to-zero", rz_bad, 0);
    chk(err_n == 0, "R9 no error on legal traffic", err_n, 0);
    rdy_toggle = 1'b0; rdy_force = 1'b1;
    cycles(50);

    // transmitter pacing with a bench-controlled acknowledge, byte E4 last
    lb = 1'b0; b_ack = 1'b0;
    send_byte(8'hE4, 1'b1);
    for (int k = 0; k < 4; k++) begin
      cycles(10);
      chk(tx_dat == (4'b0001 << k) && !tx_eop, "R3 symbol order", {tx_eop, tx_dat}, 1 << k);
      chk(!s_ready, "R5 busy during symbol", s_ready, 0);
      @(posedge clk); #1; b_ack = 1'b1;
      cycles(6);
      chk(tx_dat == 0 && !tx_eop, "R2 drop after ack", {tx_eop, tx_dat}, 0);
      cycles(10);
      chk(tx_dat == 0 && !tx_eop, "R2 wait for ack low", {tx_eop, tx_dat}, 0);
      @(posedge clk); #1; b_ack = 1'b0;
    end
    cycles(10);
    chk(tx_eop && tx_dat == 0, "R4 end token alone", {tx_eop, tx_dat}, 5'h10);
    chk(!s_ready, "R5 busy during end token", s_ready, 0);
    @(posedge clk); #1; b_ack = 1'b1;
    cycles(6);
    chk(!tx_eop, "R4 end token dropped", tx_eop, 0);
    @(posedge clk); #1; b_ack = 1'b0;
    cycles(6);
    chk(s_ready, "R5 ready after end handshake", s_ready, 1);

    // receiver driven directly
    @(posedge clk); #1; {b_eop, b_dat} = 5'b00100;
    wait_ack(1'b1, "R11 ack rise");
    cycles(10);
    chk(rx_ack, "R11 ack held while token held", rx_ack, 1);
    @(posedge clk); #1; {b_eop, b_dat} = '0;
    wait_ack(1'b0, "R11 ack fall");
    put_tok(5'b10000);  // end token cuts the byte after one symbol
    e0 = err_n; n0 = rx_n;
    put_tok(5'b00011);
    chk(err_n == e0 + 1, "R9 two data lines", err_n, e0 + 1);
    put_tok(5'b10001);
    chk(err_n == e0 + 2, "R9 data plus end line", err_n, e0 + 2);
    put_tok(5'b00100); put_tok(5'b00010); put_tok(5'b10000);
    chk(err_n == e0 + 3, "R10 end after two symbols", err_n, e0 + 3);
    chk(rx_n == n0, "R9 R10 nothing delivered", rx_n, n0);
    put_byte(8'h1B); put_byte(8'h5A); put_tok(5'b10000);
    cycles(5);
    chk(rx_n == n0 + 2, "R10 restart count", rx_n, n0 + 2);
    chk(rxbuf[n0] == 9'h01B, "R10 R7 restart byte not last", rxbuf[n0], 9'h01B);
    chk(rxbuf[n0 + 1] == 9'h15A, "R7 byte then end token", rxbuf[n0 + 1], 9'h15A);

    // back-pressure over loopback
    lb = 1'b1; rdy_force = 1'b0;
    cycles(5);
    n0 = rx_n;
    send_byte(8'hC3, 1'b0);
    send_byte(8'h7E, 1'b1);
    cycles(300);
    chk(m_valid && m_data == 8'hC3 && !m_last, "R8 output held", {m_last, m_data}, 9'h0C3);
    chk(tx_eop && !rx_ack, "R8 end token unacknowledged", {tx_eop, rx_ack}, 2'b10);
    cycles(50);
    chk(m_valid && m_data == 8'hC3, "R8 output stable", m_data, 8'hC3);
    rdy_force = 1'b1;
    cycles(300);
    chk(rx_n == n0 + 2, "R8 both delivered", rx_n, n0 + 2);
    chk(rxbuf[n0 + 1] == 9'h17E, "R8 second byte last", rxbuf[n0 + 1], 9'h17E);
    chk(s_ready && !tx_eop, "R5 idle at end", {s_ready, tx_eop}, 2'b10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule